// File: doc/BRIEF.md
# Single-Wire Command Slave

This block is the slave end of a bidirectional command link that runs over one open-drain wire, with a master that clocks every bit. Each bit slot opens with a falling edge that the master drives. The slave either samples the level the master holds during the slot, or, when it is the sender, pulls the wire low for a 0 inside a fixed window after that edge. The pad is modelled only as a pull-down enable (`pull_dn_o`). The wire level seen by the block is the wired-AND of the master and this enable.

A frame runs as follows: a start slot, three select bits (least significant first), a continue bit, four data bits (least significant first), an acknowledge slot that the slave drives, and an optional stop slot. Selections 0 to 2 write the three configuration registers. Selections 3 to 7 read switch state, the fault code, or one of the configuration registers back. Every received bit is sampled twice. If the two samples disagree, the frame is negatively acknowledged and its data is thrown away.

After reset the block sleeps. A falling edge wakes it. A frame whose continue bit is 0 is followed by a stop slot, after which the block hands the wire to modulation mode. It returns to command mode when `resume_i` pulses. Writing the standby bit ends the frame right after the last data bit.

Top module: `swire_slave`

## Requirements
- R1: After reset the block is in standby with the pull-down off and modulation mode off. The configuration registers hold their reset values: control 0000, coil code 1111, options 0001.
- R2: A falling edge on the wire while in standby ends standby, and that slot counts as the start slot of a frame.
- R3: Select value s is sent as CMD0=s[0], CMD1=s[1], CMD2=s[2]. In a frame with s in 0..2, the four data bits (Bit0 first) are written to configuration register s once the last data bit has been received without error.
- R4: Each input bit is sampled at 6 and at 10 cycles after the detected edge. If the two samples differ in any select, continue or write-data bit, the acknowledge slot is left high (N_ACKN=1), no register changes, and the next slot is a start slot.
- R5: A frame with no sampling error is acknowledged by pulling the wire low in the acknowledge slot. The error flag is clear again for the next frame.
- R6: When the continue bit is 1, the slot after the acknowledge is a new start slot and the block stays in command mode.
- R7: When the continue bit is 0, one stop slot follows the acknowledge and then modulation mode is entered. A pulse on `resume_i` returns the block to command mode.
- R8: Writing register 0 with Bit1=1 enters standby right after data bit 3. No acknowledge is driven. The other bits of register 0 are stored, and Bit1 is stored as 0.
- R9: Selections 5, 6 and 7 return registers 0, 1 and 2 on the wire, Bit0 first. A 0 bit is sent as a pull-down and a 1 bit as a released wire.
- R10: Selection 4 returns the 3-bit fault code in Bit0..Bit2 with Bit3 = 0. The codes are: 0 none, 1 open load, 2 overtemperature, 3 short to ground, 4 short to battery, 5 switch transistor short to battery. An acknowledged read of selection 4 clears the code to 0.
- R11: Selection 3 returns switch 1 in Bit0 and switch 2 in Bit1, with Bits 2 and 3 as 0. A switch that has gone low since the last acknowledged read of selection 3 reads 0 even after it has returned high.
- R12: The pull-down is asserted only from 4 to 13 cycles after the detected edge of a slot.
- R13: The pull-down is never asserted in standby or in modulation mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Synchronised level of the shared wire |
| pull_dn_o | output | 1 | Pull-down enable for the open-drain pad |
| standby_o | output | 1 | Block is asleep |
| mod_mode_o | output | 1 | Wire handed to modulation mode |
| resume_i | input | 1 | Pulse: return from modulation to command mode |
| sw_i | input | 2 | Switch levels, bit 0 = switch 1 |
| fault_set_i | input | 1 | Pulse: load `fault_code_i` into the fault register |
| fault_code_i | input | 3 | Fault code to record |
| ctrl_o | output | 4 | Register 0: carrier on, standby (reads 0), phase keying, long timeout |
| coil_o | output | 4 | Register 1: coil current code |
| opt_o | output | 4 | Register 2: clock halving, wake carrier, switch 1 and switch 2 pull-up off |

## Verification
Every result arrives at a fixed cycle count from the falling edge the block detects. A response bit is driven from cycle 4 to cycle 13 of its slot. Register, standby and mode changes appear at cycle 16 of the slot that completes them. The bench therefore runs on a slot grid with a fixed offset from the edge. It records the wire at cycle 9 of each slave-driven slot and pushes the value with its expected value into a scoreboard queue, which a monitor drains. It checks the pull-down at cycles 2 and 14 to confirm it is released outside the window. Register and mode outputs are compared only after a slot has finished, three cycles past its update edge.

// File: rtl/swire_pkg.sv
package swire_pkg;
   localparam int DATA_W   = 4;
   localparam int SEL_W    = 3;
   localparam int FAULT_W  = 3;
   localparam int NUM_CFG  = 3;
   localparam logic [SEL_W-1:0] SEL_SWITCH = 3'd3;
   localparam logic [SEL_W-1:0] SEL_FAULT  = 3'd4;
   localparam logic [SEL_W-1:0] SEL_ECHO0  = 3'd5;

   typedef enum logic [2:0] {
      PH_START,
      PH_CMD,
      PH_DATA,
      PH_ACK,
      PH_STOP
   } phase_e;
endpackage

// File: rtl/swire_slot_timer.sv
module swire_slot_timer #(
   parameter int T_SYNC = 4,
   parameter int T_S1   = 6,
   parameter int T_S2   = 10,
   parameter int T_REL  = 14,
   parameter int T_END  = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic tx_en_i,
   input  logic tx_bit_i,
   output logic fall_o,
   output logic done_o,
   output logic bit_o,
   output logic bad_o,
   output logic pull_o
);
   localparam int CW = $clog2(T_END + 1);
   localparam logic [CW-1:0] C_SYNC = CW'(T_SYNC);
   localparam logic [CW-1:0] C_S1   = CW'(T_S1);
   localparam logic [CW-1:0] C_S2   = CW'(T_S2);
   localparam logic [CW-1:0] C_REL  = CW'(T_REL);
   localparam logic [CW-1:0] C_END  = CW'(T_END);

   if (!(T_SYNC > 0 && T_SYNC < T_S1 && T_S1 < T_S2 && T_S2 < T_REL && T_REL <= T_END))
   begin : g_bad_timing
      $error("swire_slot_timer: slot offsets must be strictly ordered");
   end

   logic [CW-1:0] cnt;
   logic          line_q;
   logic          samp1;

   assign fall_o = line_q & ~line_i & (cnt == '0);
   assign done_o = (cnt == C_END);
   assign pull_o = tx_en_i & ~tx_bit_i & (cnt >= C_SYNC) & (cnt < C_REL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         line_q <= 1'b1;
         samp1  <= 1'b1;
         bit_o  <= 1'b1;
         bad_o  <= 1'b0;
      end else begin
         line_q <= line_i;
         if (fall_o)
            cnt <= CW'(1);
         else if (cnt != '0)
            cnt <= (cnt == C_END) ? '0 : cnt + CW'(1);
         if (cnt == C_S1)
            samp1 <= line_i;
         if (cnt == C_S2) begin
            bit_o <= samp1;
            bad_o <= samp1 ^ line_i;
         end
      end
   end

   // R12: the drive window opens and closes at its fixed offsets
   a_r12_drive_open: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pull_o) |-> cnt == C_SYNC);
   a_r12_drive_close: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pull_o) |-> cnt == C_REL);
endmodule

// File: rtl/swire_regfile.sv
module swire_regfile
   import swire_pkg::*;
#(
   parameter logic [NUM_CFG*DATA_W-1:0] CFG_RST = 12'h1F0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_i,
   input  logic [SEL_W-1:0]           sel_i,
   input  logic [DATA_W-1:0]          wdata_i,
   input  logic                       rd_ack_i,
   input  logic [1:0]                 sw_i,
   input  logic                       fault_set_i,
   input  logic [FAULT_W-1:0]         fault_code_i,
   output logic [DATA_W-1:0]          rdata_o,
   output logic [NUM_CFG*DATA_W-1:0]  cfg_o
);
   localparam logic [DATA_W-1:0] STBY_CLR = ~(DATA_W'(1) << 1);

   logic [DATA_W-1:0]  cfg_q [NUM_CFG];
   logic [1:0]         low_q;
   logic [FAULT_W-1:0] fault_q;
   logic               clr_sw;
   logic               clr_fault;

   assign clr_sw    = rd_ack_i && (sel_i == SEL_SWITCH);
   assign clr_fault = rd_ack_i && (sel_i == SEL_FAULT);

   for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
      localparam logic [DATA_W-1:0] KEEP = (g == 0) ? STBY_CLR : '1;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cfg_q[g] <= CFG_RST[g*DATA_W +: DATA_W];
         else if (wr_i && (sel_i == SEL_W'(g)))
            cfg_q[g] <= wdata_i & KEEP;
      end
      assign cfg_o[g*DATA_W +: DATA_W] = cfg_q[g];
   end

   for (genvar s = 0; s < 2; s++) begin : g_sw
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            low_q[s] <= 1'b0;
         else
            low_q[s] <= (low_q[s] & ~clr_sw) | ~sw_i[s];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fault_q <= '0;
      else if (fault_set_i)
         fault_q <= fault_code_i;
      else if (clr_fault)
         fault_q <= '0;
   end

   always_comb begin
      rdata_o = '0;
      if (sel_i == SEL_SWITCH)
         rdata_o = {2'b00, sw_i & ~low_q};
      else if (sel_i == SEL_FAULT)
         rdata_o = {1'b0, fault_q};
      else if (sel_i >= SEL_ECHO0)
         rdata_o = cfg_q[sel_i - SEL_ECHO0];
   end

   // R10: an acknowledged fault read leaves the code cleared
   a_r10_fault_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_fault && !fault_set_i) |=> fault_q == '0);
   // R11: a latched low level survives until its read is acknowledged
   a_r11_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (low_q[0] && !clr_sw) |=> low_q[0]);
endmodule

// File: rtl/swire_slave.sv
module swire_slave
   import swire_pkg::*;
#(
   parameter int T_SYNC = 4,
   parameter int T_S1   = 6,
   parameter int T_S2   = 10,
   parameter int T_REL  = 14,
   parameter int T_END  = 16,
   parameter logic [NUM_CFG*DATA_W-1:0] CFG_RST = 12'h1F0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         line_i,
   output logic         pull_dn_o,
   output logic         standby_o,
   output logic         mod_mode_o,
   input  logic         resume_i,
   input  logic [1:0]   sw_i,
   input  logic         fault_set_i,
   input  logic [2:0]   fault_code_i,
   output logic [3:0]   ctrl_o,
   output logic [3:0]   coil_o,
   output logic [3:0]   opt_o
);
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

   phase_e                     phase;
   logic [IDX_W-1:0]           idx;
   logic [DATA_W-1:0]          cmd_q, rx_q, tx_q;
   logic                       err_q, standby_q, mod_q;
   logic                       fall, done, bitv, bad, tx_en, tx_bit;
   logic                       is_wr, last, wr, rd_ack, stby_hit, err_now;
   logic [DATA_W-1:0]          rdata;
   logic [NUM_CFG*DATA_W-1:0]  cfg;
   logic [SEL_W-1:0]           sel;

   assign sel      = cmd_q[SEL_W-1:0];
   assign is_wr    = sel < SEL_W'(NUM_CFG);
   assign last     = idx == IDX_LAST;
   assign err_now  = err_q | bad;
   assign wr       = done && !mod_q && !standby_q && phase == PH_DATA && last && is_wr && !err_now;
   assign stby_hit = wr && sel == '0 && rx_q[1];
   assign rd_ack   = done && !mod_q && phase == PH_ACK && !is_wr && !err_q;
   assign tx_en    = !mod_q && !standby_q && ((phase == PH_DATA && !is_wr) || phase == PH_ACK);
   assign tx_bit   = (phase == PH_ACK) ? err_q : tx_q[0];

   swire_slot_timer #(
      .T_SYNC(T_SYNC), .T_S1(T_S1), .T_S2(T_S2), .T_REL(T_REL), .T_END(T_END)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .line_i(line_i), .tx_en_i(tx_en), .tx_bit_i(tx_bit),
      .fall_o(fall), .done_o(done), .bit_o(bitv), .bad_o(bad), .pull_o(pull_dn_o)
   );

   swire_regfile #(.CFG_RST(CFG_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_i(wr), .sel_i(sel),
      .wdata_i({bitv, rx_q[DATA_W-2:0]}), .rd_ack_i(rd_ack), .sw_i(sw_i),
      .fault_set_i(fault_set_i), .fault_code_i(fault_code_i),
      .rdata_o(rdata), .cfg_o(cfg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_START;
         idx       <= '0;
         cmd_q     <= '0;
         rx_q      <= '0;
         tx_q      <= '1;
         err_q     <= 1'b0;
         standby_q <= 1'b1;
         mod_q     <= 1'b0;
      end else if (mod_q) begin
         if (resume_i) begin
            mod_q <= 1'b0;
            phase <= PH_START;
         end
      end else begin
         if (fall && standby_q)
            standby_q <= 1'b0;
         if (done && !standby_q) begin
            unique case (phase)
               PH_START: begin
                  phase <= PH_CMD;
                  idx   <= '0;
               end
               PH_CMD: begin
                  cmd_q[idx] <= bitv;
                  err_q      <= err_now;
                  if (last) begin
                     phase <= PH_DATA;
                     idx   <= '0;
                     tx_q  <= rdata;
                  end else
                     idx <= idx + IDX_W'(1);
               end
               PH_DATA: begin
                  if (is_wr) begin
                     rx_q[idx] <= bitv;
                     err_q     <= err_now;
                  end else
                     tx_q <= tx_q >> 1;
                  if (last) begin
                     idx <= '0;
                     if (stby_hit) begin
                        standby_q <= 1'b1;
                        phase     <= PH_START;
                        err_q     <= 1'b0;
                     end else
                        phase <= PH_ACK;
                  end else
                     idx <= idx + IDX_W'(1);
               end
               PH_ACK: begin
                  err_q <= 1'b0;
                  phase <= (err_q || cmd_q[SEL_W]) ? PH_START : PH_STOP;
               end
               default: begin
                  mod_q <= 1'b1;
                  phase <= PH_START;
               end
            endcase
         end
      end
   end

   assign standby_o  = standby_q;
   assign mod_mode_o = mod_q;
   assign ctrl_o     = cfg[0 +: DATA_W];
   assign coil_o     = cfg[DATA_W +: DATA_W];
   assign opt_o      = cfg[2*DATA_W +: DATA_W];

   // R2: leaving standby always follows a detected falling edge
   a_r2_wake: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(standby_q) |-> $past(fall));
   // R8: standby is entered only at the end of data bit 3
   a_r8_stby_cut: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(standby_q) |-> ($past(phase) == PH_DATA && $past(idx) == IDX_LAST));
   // R7: modulation mode only follows a stop slot
   a_r7_handover: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mod_q) |-> $past(phase) == PH_STOP);
   // R13: wire left alone while asleep or modulating
   a_r13_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (standby_q || mod_q) |-> !pull_dn_o);
   // R4: a negative acknowledge leaves the wire released
   a_r4_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ACK && err_q) |-> !pull_dn_o);
   // R6: continue bit set leads straight to a new start slot
   a_r6_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !mod_q && phase == PH_ACK && cmd_q[SEL_W]) |=> phase == PH_START);
endmodule

// File: tb/tb_swire_slave.sv
module tb_swire_slave;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_line = 1'b1;
   logic       resume = 1'b0;
   logic [1:0] sw = 2'b11;
   logic       fault_set = 1'b0;
   logic [2:0] fault_code = 3'd0;
   logic       pull_dn, standby, mod_mode;
   logic [3:0] ctrl, coil, opt;
   logic       line;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   bit    exp_q[$];
   bit    obs_q[$];
   string tag_q[$];

   always #2 clk = ~clk;

   assign line = m_line & ~pull_dn;

   swire_slave dut (
      .clk(clk), .rst_n(rst_n), .line_i(line), .pull_dn_o(pull_dn),
      .standby_o(standby), .mod_mode_o(mod_mode), .resume_i(resume), .sw_i(sw),
      .fault_set_i(fault_set), .fault_code_i(fault_code),
      .ctrl_o(ctrl), .coil_o(coil), .opt_o(opt)
   );

   task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (obs_q.size() > 0) begin
         bit    e = exp_q.pop_front();
         bit    o = obs_q.pop_front();
         string t = tag_q.pop_front();
         checks++;
         if (o !== e) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", t, o, e);
         end
      end
   end

   // one bit slot; edge detected at P0, counter = k+1 between P_k and P_k+1
   task automatic slot(input bit v, input bit glitch, input bit obs, input bit exp, input string tag);
      @(negedge clk) m_line = 1'b0;
      repeat (2) @(negedge clk);
      if (obs) chk("R12 pull early", {3'b0, pull_dn}, 4'h0);
      m_line = v;
      repeat (6) @(negedge clk);
      if (glitch) m_line = ~v;
      @(negedge clk);
      if (obs) begin
         exp_q.push_back(exp);
         obs_q.push_back(line);
         tag_q.push_back(tag);
      end
      repeat (5) @(negedge clk);
      if (obs) chk("R12 pull late", {3'b0, pull_dn}, 4'h0);
      m_line = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic frame(input logic [2:0] sel, input bit cont, input logic [3:0] wd,
                        input int glitch_at, input bit exp_nack, input logic [3:0] exp_rd,
                        input string tag);
      bit is_wr = (sel < 3);
      slot(1'b1, 1'b0, 1'b0, 1'b0, "");
      for (int i = 0; i < 3; i++) slot(sel[i], glitch_at == i + 1, 1'b0, 1'b0, "");
      slot(cont, glitch_at == 4, 1'b0, 1'b0, "");
      for (int i = 0; i < 4; i++) begin
         if (is_wr) slot(wd[i], glitch_at == 5 + i, 1'b0, 1'b0, "");
         else       slot(1'b1, 1'b0, 1'b1, exp_rd[i], tag);
      end
      if (is_wr && sel == 3'd0 && wd[1] && !exp_nack) return;
      slot(1'b1, 1'b0, 1'b1, exp_nack, exp_nack ? "R4 nack" : "R5 ack");
      if (!exp_nack && !cont) slot(1'b1, 1'b0, 1'b0, 1'b0, "");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 standby", {3'b0, standby}, 4'h1);
      chk("R1 pull", {3'b0, pull_dn}, 4'h0);
      chk("R1 mod", {3'b0, mod_mode}, 4'h0);
      chk("R1 ctrl", ctrl, 4'h0);
      chk("R1 coil", coil, 4'hF);
      chk("R1 opt", opt, 4'h1);

      // R2 wake, R3 write coil, R5 ack, R6 stay
      frame(3'd1, 1'b1, 4'b0101, -1, 1'b0, 4'h0, "");
      chk("R2 awake", {3'b0, standby}, 4'h0);
      chk("R3 coil write", coil, 4'h5);
      chk("R6 command kept", {3'b0, mod_mode}, 4'h0);
      frame(3'd2, 1'b1, 4'b1010, -1, 1'b0, 4'h0, "");
      chk("R3 opt write", opt, 4'hA);

      // R4 glitch in data bit 2: dropped, retried without stop
      frame(3'd0, 1'b1, 4'b1101, 7, 1'b1, 4'h0, "");
      chk("R4 data dropped", ctrl, 4'h0);
      frame(3'd0, 1'b1, 4'b1101, -1, 1'b0, 4'h0, "");
      chk("R3 ctrl write", ctrl, 4'hD);

      // R9 readbacks
      frame(3'd5, 1'b1, 4'h0, -1, 1'b0, 4'hD, "R9 echo ctrl");
      frame(3'd6, 1'b1, 4'h0, -1, 1'b0, 4'h5, "R9 echo coil");
      frame(3'd7, 1'b1, 4'h0, -1, 1'b0, 4'hA, "R9 echo opt");

      // R4 glitch in select bit
      frame(3'd6, 1'b1, 4'h0, 2, 1'b1, 4'h5, "R4 read under error");
      chk("R4 stays command", {3'b0, mod_mode}, 4'h0);

      // R10 fault read and clear
      @(negedge clk) begin fault_set = 1'b1; fault_code = 3'd3; end
      @(negedge clk) fault_set = 1'b0;
      frame(3'd4, 1'b1, 4'h0, -1, 1'b0, 4'h3, "R10 fault code");
      frame(3'd4, 1'b1, 4'h0, -1, 1'b0, 4'h0, "R10 fault cleared");

      // R11 switch latch
      @(negedge clk) sw = 2'b10;
      repeat (3) @(negedge clk);
      sw = 2'b11;
      frame(3'd3, 1'b1, 4'h0, -1, 1'b0, 4'h2, "R11 latched low");
      frame(3'd3, 1'b1, 4'h0, -1, 1'b0, 4'h3, "R11 latch cleared");

      // R7 stop and handover, R13 quiet in modulation
      frame(3'd6, 1'b0, 4'h0, -1, 1'b0, 4'h5, "R9 echo coil");
      chk("R7 modulation entered", {3'b0, mod_mode}, 4'h1);
      slot(1'b1, 1'b0, 1'b1, 1'b1, "R13 no drive in modulation");
      @(negedge clk) resume = 1'b1;
      @(negedge clk) resume = 1'b0;
      chk("R7 resumed", {3'b0, mod_mode}, 4'h0);

      // R8 standby write
      frame(3'd0, 1'b1, 4'b0011, -1, 1'b0, 4'h0, "");
      chk("R8 standby", {3'b0, standby}, 4'h1);
      chk("R8 no ack drive", {3'b0, pull_dn}, 4'h0);
      chk("R8 ctrl stored", ctrl, 4'h1);
      frame(3'd5, 1'b1, 4'h0, -1, 1'b0, 4'h1, "R8 stby reads 0");
      chk("R2 rewake", {3'b0, standby}, 4'h0);

      repeat (4) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule